// File: doc/BRIEF.md
# Frame-Transfer CCD Sequence Controller

This block steps a frame-transfer CCD through its frame cycle. Every frame opens with a clear pulse on the overflow drain, then an integration interval whose length is set per frame in clock cycles. In line-sum mode a single summing pulse follows. Next comes the parallel shift of the image into the storage area, and last a line-by-line readout. The block drives logic-level enables only: the drain clear pulse, a reversed-polarity drain strobe during the shift, the two image-area gate phases and the storage gate. A separate serial sequencer handles the pixels and reports each finished line back over a request/done handshake.

Four readout modes are supported: interlaced, progressive through one serial register, progressive through both registers in parallel (line pairs), and line summing. The field flag alternates between frames in the interlaced and line-sum modes. The field sets the length of the shift and which gate phase receives the summing pulse. A mode request may arrive at any time, but it takes effect only when the next frame begins.

The clock rate is given in MHz. The minimum clear length (1 µs) and the gate pulse width follow from it, so the gate clock never exceeds 12.5 MHz.

Top module: `ccd_frame_seq`

## Requirements
- R1: While `rst` is high: `drain_clear` is 1, all gate, strobe and request outputs are 0, `field_odd` is 0, `mode_cur` is 0 (interlaced) and `expo_clamped` is 0.
- R2: Each frame starts with `drain_clear` high for exactly CLK_MHZ cycles (1 µs), with no gate, strobe or line request active. The phases always follow the order clear, integrate, optional sum, transfer, readout.
- R3: The integration interval lasts the value on `expo_cyc` sampled in the last clear cycle. If that value is below CLK_MHZ, the interval lasts CLK_MHZ cycles.
- R4: During the transfer, `img_gate_a`, `img_gate_b` and `stor_gate` pulse together. Each pulse is high for H cycles and low for H cycles, where H = ceil(CLK_MHZ/25). There are LINES_BASE+`field_odd` pulses in interlaced (0) and line-sum (3) modes, and LINES_BASE pulses in progressive modes (1, 2).
- R5: `drain_rev` is high in every cycle of the transfer and in no other cycle.
- R6: In line-sum mode one extra pulse (H high, H low) comes between integration and transfer. It goes on `img_gate_a` when `field_odd` is 0 and on `img_gate_b` when it is 1, with `stor_gate` low.
- R7: Readout issues LINES_BASE line requests in mode 1 and LINES_BASE/2 in modes 0, 2 and 3. Each `line_req` is a one-cycle pulse, and the next request follows in the cycle after `line_done` is seen. `line_pair` is high with `line_req` only in mode 2.
- R8: `line_done` has no effect unless a line request is outstanding.
- R9: At each frame boundary, `field_odd` becomes 0 if the finished or the next frame is progressive. Otherwise it inverts.
- R10: `mode_cur` changes only on entry to a clear phase. It then takes the latest request (`mode_req` with `mode_req_vld`) made during the previous frame, including one made in its final cycle.
- R11: `expo_clamped` goes high in the first integration cycle of a frame whose exposure was clamped, and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_req | input | 2 | Requested mode: 0 interlaced, 1 progressive single, 2 progressive dual, 3 line sum |
| mode_req_vld | input | 1 | Qualifies `mode_req` for one cycle |
| expo_cyc | input | EXPO_W | Integration length in cycles |
| line_done | input | 1 | Serial sequencer finished the requested line |
| drain_clear | output | 1 | Overflow-drain clear pulse |
| drain_rev | output | 1 | Reversed-polarity drain strobe during transfer |
| img_gate_a | output | 1 | Image-area gate phase A |
| img_gate_b | output | 1 | Image-area gate phase B |
| stor_gate | output | 1 | Storage-area gate |
| line_req | output | 1 | One-cycle request for a line readout |
| line_pair | output | 1 | Request covers a line pair on both registers |
| field_odd | output | 1 | Current field (0 = field 1, 1 = field 2) |
| mode_cur | output | 2 | Mode of the running frame |
| expo_clamped | output | 1 | Sticky: an exposure was clamped |

## Verification
The bench builds the block with CLK_MHZ=4 and LINES_BASE=8. This gives a 4-cycle clear, single-cycle gate half-periods, 8 or 9 transfer pulses and 4 or 8 readout lines, so a run of seven frames passes through every mode, both fields and both summing phases. Exposures below, at and above the 4-cycle floor exercise the clamp. Mode requests are placed in the first clear cycle, inside integration and in the last readout cycle, which tests frame-boundary application. Stray `line_done` pulses are placed outside any outstanding request.

// File: rtl/ccd_seq_pkg.sv
package ccd_seq_pkg;

    typedef enum logic [1:0] {
        MODE_ILACE = 2'd0,
        MODE_PROG1 = 2'd1,
        MODE_PROG2 = 2'd2,
        MODE_LSUM  = 2'd3
    } rd_mode_e;

    typedef enum logic [2:0] {
        PH_CLEAR = 3'd0,
        PH_INTEG = 3'd1,
        PH_SUM   = 3'd2,
        PH_XFER  = 3'd3,
        PH_READ  = 3'd4
    } seq_phase_e;

    function automatic logic is_prog(rd_mode_e m);
        return (m == MODE_PROG1) || (m == MODE_PROG2);
    endfunction

    // Shift length into storage: interleaved modes add one pulse in field 2.
    function automatic int unsigned xfer_count(rd_mode_e m, logic fld, int unsigned base);
        if (is_prog(m))
            return base;
        return base + (fld ? 1 : 0);
    endfunction

    function automatic int unsigned read_count(rd_mode_e m, int unsigned base);
        if (m == MODE_PROG1)
            return base;
        return base / 2;
    endfunction

    function automatic logic next_field(rd_mode_e done_m, rd_mode_e new_m, logic fld);
        if (is_prog(done_m) || is_prog(new_m))
            return 1'b0;
        return ~fld;
    endfunction

endpackage

// File: rtl/ccd_gate_pulser.sv
module ccd_gate_pulser #(
    parameter int HALF = 1,
    parameter int CW   = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [CW-1:0] n_pulses,
    output logic          gate_hi,
    output logic          last
);
    localparam int SW = $clog2(2 * HALF + 1);
    localparam logic [SW-1:0] SUB_END = SW'(2 * HALF - 1);
    localparam logic [SW-1:0] SUB_HI  = SW'(HALF);

    logic          active;
    logic [SW-1:0] sub;
    logic [CW-1:0] pcnt;
    logic [CW-1:0] ntot;
    logic          sub_end;

    assign sub_end = (sub == SUB_END);
    assign last    = active && sub_end && (pcnt == ntot - CW'(1));
    assign gate_hi = active && (sub < SUB_HI);

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            sub    <= '0;
            pcnt   <= '0;
            ntot   <= '0;
        end else if (start) begin
            active <= 1'b1;
            sub    <= '0;
            pcnt   <= '0;
            ntot   <= n_pulses;
        end else if (last) begin
            active <= 1'b0;
        end else if (active) begin
            if (sub_end) begin
                sub  <= '0;
                pcnt <= pcnt + CW'(1);
            end else begin
                sub <= sub + SW'(1);
            end
        end
    end
endmodule

// File: rtl/ccd_line_reader.sv
module ccd_line_reader #(
    parameter int CW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [CW-1:0] n_lines,
    input  logic          line_done,
    output logic          line_req,
    output logic          last
);
    logic          active;
    logic          waiting;
    logic [CW-1:0] cnt;
    logic [CW-1:0] ntot;
    logic          got_done;

    assign line_req = active && !waiting;
    assign got_done = active && waiting && line_done;
    assign last     = got_done && (cnt == ntot - CW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= 1'b0;
            waiting <= 1'b0;
            cnt     <= '0;
            ntot    <= '0;
        end else if (start) begin
            active  <= 1'b1;
            waiting <= 1'b0;
            cnt     <= '0;
            ntot    <= n_lines;
        end else if (line_req) begin
            waiting <= 1'b1;
        end else if (got_done) begin
            waiting <= 1'b0;
            if (last)
                active <= 1'b0;
            else
                cnt <= cnt + CW'(1);
        end
    end
endmodule

// File: rtl/ccd_frame_seq.sv
module ccd_frame_seq
    import ccd_seq_pkg::*;
#(
    parameter int CLK_MHZ    = 50,
    parameter int EXPO_W     = 22,
    parameter int LINES_BASE = 500
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        mode_req,
    input  logic              mode_req_vld,
    input  logic [EXPO_W-1:0] expo_cyc,
    input  logic              line_done,
    output logic              drain_clear,
    output logic              drain_rev,
    output logic              img_gate_a,
    output logic              img_gate_b,
    output logic              stor_gate,
    output logic              line_req,
    output logic              line_pair,
    output logic              field_odd,
    output logic [1:0]        mode_cur,
    output logic              expo_clamped
);
    localparam int CLEAR_CYC = CLK_MHZ;
    localparam int GATE_HALF = (CLK_MHZ + 24) / 25;
    localparam int CW        = $clog2(LINES_BASE + 2);
    localparam logic [EXPO_W-1:0] CLEAR_LIM = EXPO_W'(CLEAR_CYC);

    seq_phase_e        ph;
    logic [EXPO_W-1:0] tcnt;
    logic [EXPO_W-1:0] elen;
    rd_mode_e          mode_q;
    rd_mode_e          pend_q;
    logic              pend_vld;
    logic              fld;
    logic              clamped;

    logic              clr_end, int_end, frame_end;
    logic              pls_start, pls_hi, pls_last;
    logic              rd_start, rd_last;
    logic [CW-1:0]     pls_n, rd_n;
    rd_mode_e          mode_next;
    logic              short_expo;

    assign clr_end    = (ph == PH_CLEAR) && (tcnt == CLEAR_LIM - EXPO_W'(1));
    assign int_end    = (ph == PH_INTEG) && (tcnt == elen - EXPO_W'(1));
    assign pls_start  = int_end || ((ph == PH_SUM) && pls_last);
    assign pls_n      = ((ph == PH_INTEG) && (mode_q == MODE_LSUM))
                        ? CW'(1) : CW'(xfer_count(mode_q, fld, LINES_BASE));
    assign rd_start   = (ph == PH_XFER) && pls_last;
    assign rd_n       = CW'(read_count(mode_q, LINES_BASE));
    assign frame_end  = (ph == PH_READ) && rd_last;
    assign mode_next  = mode_req_vld ? rd_mode_e'(mode_req)
                      : (pend_vld ? pend_q : mode_q);
    assign short_expo = (expo_cyc < CLEAR_LIM);

    ccd_gate_pulser #(.HALF(GATE_HALF), .CW(CW)) u_pulse (
        .clk      (clk),
        .rst      (rst),
        .start    (pls_start),
        .n_pulses (pls_n),
        .gate_hi  (pls_hi),
        .last     (pls_last)
    );

    ccd_line_reader #(.CW(CW)) u_read (
        .clk       (clk),
        .rst       (rst),
        .start     (rd_start),
        .n_lines   (rd_n),
        .line_done (line_done),
        .line_req  (line_req),
        .last      (rd_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ph       <= PH_CLEAR;
            tcnt     <= '0;
            elen     <= CLEAR_LIM;
            mode_q   <= MODE_ILACE;
            pend_q   <= MODE_ILACE;
            pend_vld <= 1'b0;
            fld      <= 1'b0;
            clamped  <= 1'b0;
        end else begin
            if (mode_req_vld) begin
                pend_q   <= rd_mode_e'(mode_req);
                pend_vld <= 1'b1;
            end
            case (ph)
                PH_CLEAR: begin
                    if (clr_end) begin
                        ph   <= PH_INTEG;
                        tcnt <= '0;
                        elen <= short_expo ? CLEAR_LIM : expo_cyc;
                        if (short_expo)
                            clamped <= 1'b1;
                    end else begin
                        tcnt <= tcnt + EXPO_W'(1);
                    end
                end
                PH_INTEG: begin
                    if (int_end) begin
                        ph   <= (mode_q == MODE_LSUM) ? PH_SUM : PH_XFER;
                        tcnt <= '0;
                    end else begin
                        tcnt <= tcnt + EXPO_W'(1);
                    end
                end
                PH_SUM:  if (pls_last) ph <= PH_XFER;
                PH_XFER: if (pls_last) ph <= PH_READ;
                PH_READ: begin
                    if (frame_end) begin
                        ph       <= PH_CLEAR;
                        mode_q   <= mode_next;
                        pend_vld <= 1'b0;
                        fld      <= next_field(mode_q, mode_next, fld);
                    end
                end
                default: ph <= PH_CLEAR;
            endcase
        end
    end

    assign drain_clear  = (ph == PH_CLEAR);
    assign drain_rev    = (ph == PH_XFER);
    assign img_gate_a   = pls_hi && ((ph == PH_XFER) || ((ph == PH_SUM) && !fld));
    assign img_gate_b   = pls_hi && ((ph == PH_XFER) || ((ph == PH_SUM) && fld));
    assign stor_gate    = pls_hi && (ph == PH_XFER);
    assign line_pair    = line_req && (mode_q == MODE_PROG2);
    assign field_odd    = fld;
    assign mode_cur     = mode_q;
    assign expo_clamped = clamped;
endmodule

// File: rtl/ccd_frame_seq_chk.sv
module ccd_frame_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       drain_clear,
    input logic       drain_rev,
    input logic       img_gate_a,
    input logic       img_gate_b,
    input logic       stor_gate,
    input logic       line_req,
    input logic       line_pair,
    input logic       field_odd,
    input logic [1:0] mode_cur,
    input logic       expo_clamped
);
    assert_clear_alone_R2: assert property (@(posedge clk) disable iff (rst)
        drain_clear |-> !(img_gate_a || img_gate_b || stor_gate || line_req || drain_rev));

    assert_stor_with_image_R4: assert property (@(posedge clk) disable iff (rst)
        stor_gate |-> (img_gate_a && img_gate_b && drain_rev));

    assert_sum_single_phase_R6: assert property (@(posedge clk) disable iff (rst)
        (img_gate_a ^ img_gate_b) |-> (!stor_gate && !drain_rev));

    assert_req_one_cycle_R7: assert property (@(posedge clk) disable iff (rst)
        line_req |=> !line_req);

    assert_pair_with_req_R7: assert property (@(posedge clk) disable iff (rst)
        line_pair |-> line_req);

    assert_field_at_boundary_R9: assert property (@(posedge clk) disable iff (rst)
        !$stable(field_odd) |-> (drain_clear && !$past(drain_clear)));

    assert_mode_at_boundary_R10: assert property (@(posedge clk) disable iff (rst)
        !$stable(mode_cur) |-> (drain_clear && !$past(drain_clear)));

    assert_clamp_sticky_R11: assert property (@(posedge clk) disable iff (rst)
        $past(expo_clamped) |-> expo_clamped);
endmodule

bind ccd_frame_seq ccd_frame_seq_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .drain_clear  (drain_clear),
    .drain_rev    (drain_rev),
    .img_gate_a   (img_gate_a),
    .img_gate_b   (img_gate_b),
    .stor_gate    (stor_gate),
    .line_req     (line_req),
    .line_pair    (line_pair),
    .field_odd    (field_odd),
    .mode_cur     (mode_cur),
    .expo_clamped (expo_clamped)
);

// File: tb/sim_ccd_frame_seq.sv
module sim_ccd_frame_seq;
    localparam int CLK_PERIOD = 10;
    localparam int CLK_MHZ    = 4;
    localparam int EXPO_W     = 8;
    localparam int LB         = 8;
    localparam int CM         = CLK_MHZ;
    localparam int XH         = (CLK_MHZ + 24) / 25;
    localparam int DLY        = 2;
    localparam int NF         = 7;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [1:0]        mode_req = '0;
    logic              mode_req_vld = 1'b0;
    logic [EXPO_W-1:0] expo_cyc = '0;
    logic              line_done = 1'b0;
    logic drain_clear, drain_rev, img_gate_a, img_gate_b, stor_gate;
    logic line_req, line_pair, field_odd, expo_clamped;
    logic [1:0] mode_cur;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit finished = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ccd_frame_seq #(.CLK_MHZ(CLK_MHZ), .EXPO_W(EXPO_W), .LINES_BASE(LB)) u0 (
        .clk(clk), .rst(rst), .mode_req(mode_req), .mode_req_vld(mode_req_vld),
        .expo_cyc(expo_cyc), .line_done(line_done),
        .drain_clear(drain_clear), .drain_rev(drain_rev),
        .img_gate_a(img_gate_a), .img_gate_b(img_gate_b), .stor_gate(stor_gate),
        .line_req(line_req), .line_pair(line_pair), .field_odd(field_odd),
        .mode_cur(mode_cur), .expo_clamped(expo_clamped)
    );

    // Expected stream: one entry per clock cycle, with the inputs to drive in it.
    logic [10:0] exq[$];
    bit          dnq[$];
    bit          rqq[$];
    logic [1:0]  rqmq[$];
    int          exoq[$];
    string       tgq[$];

    int m_fld = 0, m_mode = 0, m_clamp = 0, m_expo = 0;

    task automatic push(input bit dc, dn, ga, gb, sg, lr, lp, input string t);
        exq.push_back({dc, dn, ga, gb, sg, lr, lp, 1'(m_fld), 2'(m_mode), 1'(m_clamp)});
        dnq.push_back(1'b0);
        rqq.push_back(1'b0);
        rqmq.push_back(2'd0);
        exoq.push_back(m_expo);
        tgq.push_back(t);
    endtask

    function automatic bit prog(int m);
        return (m == 1) || (m == 2);
    endfunction

    function automatic string btag(int b);
        case (b)
            10: return "R2";
            9: return "R5";
            8, 7: return "R4/R6";
            6: return "R4";
            5, 4: return "R7";
            3: return "R9";
            2, 1: return "R10";
            default: return "R11";
        endcase
    endfunction

    task automatic build();
        int fm[NF] = '{0, 3, 1, 2, 0, 0, 3};
        int fe[NF] = '{6, 2, 5, 4, 3, 7, 5};
        // request placement: 0 none, 1 first integrate cycle, 2 first clear cycle, 3 last readout cycle
        int rk[NF] = '{1, 2, 3, 1, 0, 3, 0};
        for (int f = 0; f < NF; f++) begin
            int m = fm[f];
            int elen, np, nl, nm, first;
            m_expo = fe[f];
            first = exq.size();
            for (int k = 0; k < CM; k++) push(1, 0, 0, 0, 0, 0, 0, "R2");
            if (rk[f] == 2) begin rqq[first] = 1; rqmq[first] = 2'(fm[f+1]); tgq[first] = "R10"; end
            if (fe[f] < CM) m_clamp = 1;
            elen = (fe[f] < CM) ? CM : fe[f];
            first = exq.size();
            for (int k = 0; k < elen; k++) push(0, 0, 0, 0, 0, 0, 0, "R3");
            if (rk[f] == 1) begin rqq[first] = 1; rqmq[first] = 2'(fm[f+1]); end
            if (f == 4) begin dnq[first] = 1; tgq[first] = "R8"; end
            if (m == 3) begin
                for (int k = 0; k < XH; k++) push(0, 0, m_fld == 0, m_fld == 1, 0, 0, 0, "R6");
                for (int k = 0; k < XH; k++) push(0, 0, 0, 0, 0, 0, 0, "R6");
            end
            np = prog(m) ? LB : LB + m_fld;
            for (int p = 0; p < np; p++) begin
                for (int k = 0; k < XH; k++) push(0, 1, 1, 1, 1, 0, 0, "R4");
                for (int k = 0; k < XH; k++) push(0, 1, 0, 0, 0, 0, 0, "R5");
            end
            nl = (m == 1) ? LB : LB / 2;
            for (int l = 0; l < nl; l++) begin
                push(0, 0, 0, 0, 0, 1, m == 2, "R7");
                if (f == 2 && l == 0) begin dnq[dnq.size()-1] = 1; tgq[tgq.size()-1] = "R8"; end
                for (int d = 0; d < DLY; d++) push(0, 0, 0, 0, 0, 0, 0, "R7");
                dnq[dnq.size()-1] = 1;
            end
            if (rk[f] == 3) begin rqq[rqq.size()-1] = 1; rqmq[rqmq.size()-1] = 2'(fm[f+1]); end
            nm = (f < NF - 1) ? fm[f+1] : m;
            m_fld = (prog(m) || prog(nm)) ? 0 : (m_fld ^ 1);
            m_mode = nm;
        end
    endtask

    function automatic logic [10:0] observed();
        return {drain_clear, drain_rev, img_gate_a, img_gate_b, stor_gate,
                line_req, line_pair, field_odd, mode_cur, expo_clamped};
    endfunction

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000 && !finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not end, got cycle %0d expected below 20000", cyc);
            finish_run();
        end
    end

    initial begin
        logic [10:0] got;
        build();
        repeat (2) @(negedge clk);
        // R1: reset state
        got = observed();
        total++;
        if (got !== 11'b10000000000) begin
            bad++;
            $display("FAIL R1 reset state got %b exp %b", got, 11'b10000000000);
        end
        for (int i = 0; i < exq.size(); i++) begin
            @(negedge clk);
            rst          = 1'b0;
            line_done    = dnq[i];
            mode_req_vld = rqq[i];
            mode_req     = rqmq[i];
            expo_cyc     = EXPO_W'(exoq[i]);
            got = observed();
            total++;
            if (got !== exq[i]) begin
                int b = 0;
                for (int k = 0; k < 11; k++) if (got[k] !== exq[i][k]) b = k;
                bad++;
                $display("FAIL %s (%s) cycle %0d got %b exp %b", tgq[i], btag(b), i, got, exq[i]);
            end
        end
        @(negedge clk);
        finish_run();
    end
endmodule